// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Mode and Level Flags

This block is an 18-bit first-in first-out buffer whose write and read sides run on unrelated clocks. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other clock domain through two flops. As a result, every flag a side computes from the other side's pointer is late, and only in the safe direction.

The output mode is captured while master reset is held. In standard mode the two status outputs report full and empty, and a word moves to the data output only when the reader asks for it. In fall-through mode the same two outputs report room-to-write and word-present. The oldest word is moved into an output stage without any request, and a read strobe consumes it.

There are three level flags: almost-full, almost-empty and over-half. Their thresholds come from an external offset-register block. A partial reset clears the data path but keeps the mode. Retransmit sends again the data held from the first memory location onward.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low, both pointers and `rdata` are cleared and the level on `mode_sel` is captured (1 = fall-through, 0 = standard). After release in standard mode, `st_wr`=0, `st_rd`=1, `rdata`=0, `ae_n`=0, `af_n`=1 and `hf`=0.
- R2: While `prst_n` is low, both pointers and `rdata` are cleared. The captured mode is kept whatever level `mode_sel` has.
- R3: In standard mode, `st_wr` is 1 exactly when DEPTH words are held, and `st_rd` is 1 exactly when none is held. A write while full is ignored.
- R4: In standard mode, `ren` high at a read-clock edge with data present loads the oldest word into `rdata` at that edge. Words leave in the order they were written.
- R5: In fall-through mode, `st_wr` is 1 while space is left. The oldest word appears on `rdata` with `st_rd`=1 without `ren`. `ren` consumes it and brings up the next word.
- R6: `af_n` is 0 when the number of free locations is at or below `off_full`, and 1 when it is above.
- R7: `ae_n` is 0 when the stored word count is at or below `off_empty`, and 1 when it is above.
- R8: `hf` is 1 when more than DEPTH/2 words are held, and 0 otherwise.
- R9: A one-cycle `retx` pulse on the read clock returns the read pointer to memory location 0, so the same data is read out again.
- R10: In standard mode, a read while empty is ignored and `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, clears pointers and captures mode |
| prst_n | input | 1 | Partial reset, active low, clears pointers and keeps mode |
| mode_sel | input | 1 | Mode level sampled during master reset (1 = fall-through) |
| retx | input | 1 | Retransmit pulse, read clock domain |
| wen | input | 1 | Write enable |
| wdata | input | DW | Write data |
| ren | input | 1 | Read enable / pop strobe |
| off_full | input | AW+1 | Almost-full threshold in free locations |
| off_empty | input | AW+1 | Almost-empty threshold in stored words |
| rdata | output | DW | Data output register |
| st_wr | output | 1 | Full (standard) or input-ready (fall-through) |
| st_rd | output | 1 | Empty (standard) or output-ready (fall-through) |
| af_n | output | 1 | Almost-full, active low |
| ae_n | output | 1 | Almost-empty, active low |
| hf | output | 1 | More than half full |

## Verification
A rising fill, one word at a time, walks the occupancy across each threshold. This separates an inclusive comparison from an exclusive one at the almost-empty, over-half and almost-full boundaries, and reaches the full state, where an extra write must leave the read-back sequence unchanged. A full drain in standard mode checks ordering and then the ignored read on empty. A short burst in fall-through mode shows that data appears with no request, and a partial reset taken with the mode input flipped shows whether the mode was kept. A write, read, retransmit, read sequence tells a pointer rewind apart from a plain reset, because the same words must return without being written again.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          retx,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          ren,
  input  logic [AW:0]   off_full,
  input  logic [AW:0]   off_empty,
  output logic [DW-1:0] rdata,
  output logic          st_wr,
  output logic          st_rd,
  output logic          af_n,
  output logic          ae_n,
  output logic          hf
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HALF_V  = {2'b01, {(AW-1){1'b0}}};

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DW-1:0] mem [DEPTH];
  logic          fwft;

  always_ff @(posedge wclk)
    if (!mrst_n) fwft <= mode_sel;

  // write domain
  logic [AW:0] wbin, wgray, rg_s1, rg_s2, cnt_w, free_w;
  logic        full, wr_go;

  assign cnt_w  = wbin - g2b(rg_s2);
  assign free_w = DEPTH_V - cnt_w;
  assign full   = (cnt_w == DEPTH_V);
  assign wr_go  = wen & ~full;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;

  assign st_wr = fwft ? ~full : full;
  assign af_n  = ~(free_w <= off_full);
  assign hf    = (cnt_w > HALF_V);

  // read domain
  logic [AW:0]   rbin, rgray, wg_s1, wg_s2, cnt_r;
  logic [AW+1:0] lvl_r;
  logic          mem_empty, rd_go, out_vld;

  assign cnt_r     = g2b(wg_s2) - rbin;
  assign mem_empty = (cnt_r == '0);
  assign rd_go     = ~mem_empty & (fwft ? (~out_vld | ren) : ren);
  assign lvl_r     = {1'b0, cnt_r} + {{(AW+1){1'b0}}, fwft & out_vld};

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rdata   <= '0;
      out_vld <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (retx) begin
        rbin    <= '0;
        rgray   <= '0;
        out_vld <= 1'b0;
      end else begin
        if (rd_go) begin
          rdata <= mem[rbin[AW-1:0]];
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
        end
        if (fwft) out_vld <= rd_go | (out_vld & ~ren);
      end
    end

  assign st_rd = fwft ? out_vld : mem_empty;
  assign ae_n  = ~(lvl_r <= {1'b0, off_empty});

  // checks
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && full) |=> $stable(wbin));

  p_wgray_step_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_no_underflow_r10: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && ren && mem_empty && !retx) |=> $stable(rdata));

  p_head_held_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && out_vld && !ren && !retx) |=> (out_vld && $stable(rdata)));

  p_full_over_half_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> hf);

  p_full_almost_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> !af_n);
endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, mode_sel = 0, retx = 0, wen = 0, ren = 0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0] off_full = 5'd2, off_empty = 5'd3;
  logic [DW-1:0] rdata;
  logic st_wr, st_rd, af_n, ae_n, hf;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dual_mode_fifo #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .retx(retx), .wen(wen), .wdata(wdata), .ren(ren),
    .off_full(off_full), .off_empty(off_empty), .rdata(rdata),
    .st_wr(st_wr), .st_rd(st_rd), .af_n(af_n), .ae_n(ae_n), .hf(hf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1; wdata = d;
    @(posedge wclk); #1;
    wen = 0;
  endtask

  task automatic rd_std(input string req, input logic [DW-1:0] exp);
    @(negedge rclk);
    ren = 1;
    @(posedge rclk); #1;
    ren = 0;
    chk(req, 32'(rdata), 32'(exp));
  endtask

  task automatic pop();
    @(negedge rclk);
    ren = 1;
    @(posedge rclk); #1;
    ren = 0;
  endtask

  task automatic do_mrst(input logic m);
    mode_sel = m; mrst_n = 0;
    repeat (4) @(negedge wclk);
    repeat (2) @(negedge rclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic do_prst(input logic m);
    mode_sel = m; prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    settle();
  endtask

  task automatic t_master_reset();
    do_mrst(1'b0);
    chk("R1 st_wr", 32'(st_wr), 0);
    chk("R1 st_rd", 32'(st_rd), 1);
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 ae_n", 32'(ae_n), 0);
    chk("R1 af_n", 32'(af_n), 1);
    chk("R1 hf", 32'(hf), 0);
  endtask

  task automatic t_levels_and_order();
    for (int i = 0; i < 3; i++) wr(18'h100 + 18'(i));
    settle();
    chk("R7 ae_n at offset", 32'(ae_n), 0);
    chk("R3 not empty", 32'(st_rd), 0);
    wr(18'h103); settle();
    chk("R7 ae_n above offset", 32'(ae_n), 1);
    for (int i = 4; i < 8; i++) wr(18'h100 + 18'(i));
    chk("R8 hf at half", 32'(hf), 0);
    wr(18'h108); #1;
    chk("R8 hf above half", 32'(hf), 1);
    for (int i = 9; i < 13; i++) wr(18'h100 + 18'(i));
    chk("R6 af_n free 3", 32'(af_n), 1);
    wr(18'h10D); #1;
    chk("R6 af_n free 2", 32'(af_n), 0);
    wr(18'h10E);
    chk("R3 not yet full", 32'(st_wr), 0);
    wr(18'h10F);
    chk("R3 full", 32'(st_wr), 1);
    wr(18'h3FFFF);
    chk("R3 still full", 32'(st_wr), 1);
    settle();
    for (int i = 0; i < DEPTH; i++) rd_std("R4 order", 18'h100 + 18'(i));
    settle();
    chk("R3 empty after drain", 32'(st_rd), 1);
    rd_std("R10 read on empty", 18'h10F);
  endtask

  task automatic t_retransmit();
    do_prst(1'b0);
    chk("R2 rdata cleared", 32'(rdata), 0);
    wr(18'h0AA); wr(18'h0BB); wr(18'h0CC);
    settle();
    rd_std("R4 first pass", 18'h0AA);
    rd_std("R4 first pass", 18'h0BB);
    rd_std("R4 first pass", 18'h0CC);
    settle();
    chk("R3 empty before rewind", 32'(st_rd), 1);
    @(negedge rclk); retx = 1;
    @(negedge rclk); retx = 0;
    settle();
    chk("R9 data back", 32'(st_rd), 0);
    rd_std("R9 resend", 18'h0AA);
    rd_std("R9 resend", 18'h0BB);
    rd_std("R9 resend", 18'h0CC);
  endtask

  task automatic t_fall_through();
    do_mrst(1'b1);
    chk("R5 ready to write", 32'(st_wr), 1);
    chk("R5 nothing out", 32'(st_rd), 0);
    wr(18'h2A5); wr(18'h15A);
    settle();
    chk("R5 head valid", 32'(st_rd), 1);
    chk("R5 head data", 32'(rdata), 32'h2A5);
    pop(); settle();
    chk("R5 next data", 32'(rdata), 32'h15A);
    chk("R5 next valid", 32'(st_rd), 1);
    pop(); settle();
    chk("R5 drained", 32'(st_rd), 0);
    do_prst(1'b0);
    chk("R2 mode kept", 32'(st_wr), 1);
    chk("R2 rdata zero", 32'(rdata), 0);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    bad++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_master_reset();
    t_levels_and_order();
    t_retransmit();
    t_fall_through();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule